// File: doc/BRIEF.md
# Supply Switchover Time Stamp Recorder

This block keeps a record of when a system changed power source. A supply monitor outside the block sends a one-cycle strobe when the system falls back to its backup battery and another when main power returns. On each strobe the block copies the packed calendar value from the clock counter into one of two stamp banks, and it sets a valid flag for that bank. The calendar counter and the analog sensing are not part of this block.

The two banks keep their contents in opposite ways. The fall-back (power-down) bank keeps the first event it saw and holds that value until software sends the clear command. The return (power-up) bank is overwritten on every return event, so it always holds the latest one. Software reads both banks one byte at a time through a small address/data port. Each byte is latched on a read strobe.

Top module: `stamp_top`

## Requirements
- R1: After reset both valid flags are 0 and every stamp byte reads as 0.
- R2: In the cycle where `enterBackup` is high and the power-down bank is empty, the full calendar value on `timeNow` is stored in that bank and its valid flag is set.
- R3: While the power-down valid flag is 1 and no clear is given, later `enterBackup` strobes leave the power-down bank unchanged, so the first event is kept.
- R4: A strobe on `exitBackup` stores `timeNow` into the power-up bank and sets its valid flag.
- R5: Every later `exitBackup` strobe overwrites the power-up bank, so it holds the latest event.
- R6: `clearStamps` zeroes both banks and clears both valid flags.
- R7: When `clearStamps` and an event strobe come in the same cycle, the capture wins. That bank holds the new value with its flag set, and the bank that had no event is cleared.
- R8: The read map is as follows. `rdAddr[3]` selects the bank: 0 is power-down and 1 is power-up. Indices 0 to 6 of `rdAddr[2:0]` return byte `timeNow[8*i +: 8]` as it was captured (seconds, minutes, hours, date, month, year, day of week). Index 7 returns the flag byte, with bit 0 the power-down valid flag and bit 1 the power-up valid flag. `rdData` takes the selected byte on the edge where `rdEn` is high and keeps its value otherwise.
- R9: When `enterBackup` and `exitBackup` come in the same cycle, each bank captures the same value under its own policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enterBackup | input | 1 | One-cycle strobe: supply switched to battery |
| exitBackup | input | 1 | One-cycle strobe: supply switched back to main |
| timeNow | input | 56 | Packed calendar value, 7 bytes |
| clearStamps | input | 1 | Clear command for both banks |
| rdEn | input | 1 | Status read strobe |
| rdAddr | input | 4 | Read address: bank bit and byte index |
| rdData | output | 8 | Registered read data |

## Verification
A clear command and a power-down capture can fall in the same cycle. To provoke this, the bench first fills both banks, then drives `clearStamps` and `enterBackup` high on one edge with a new calendar value. It judges the result by reading back every byte and the flag byte. The power-down bank must hold the new value with its flag set, and the power-up bank must read zero with its flag clear. A second collision drives both event strobes together after a clear, and the bench checks that each bank took the shared value.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int FIELD_W_DEF     = 8;
  localparam int FIELD_COUNT_DEF = 7;
  localparam int ADDR_W_DEF      = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic captureDown;
    logic captureUp;
    logic wipeDown;
    logic wipeUp;
  } stampStrobe_t;
endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enterBackup,
  input  logic         exitBackup,
  input  logic         clearStamps,
  output stampStrobe_t strobes,
  output logic         downValid,
  output logic         upValid
);

  // the power-down bank captures only while empty, unless a clear frees it in the same cycle
  always_comb begin
    strobes.captureDown = enterBackup && (!downValid || clearStamps);
    strobes.captureUp   = exitBackup;
    strobes.wipeDown    = clearStamps && !strobes.captureDown;
    strobes.wipeUp      = clearStamps && !strobes.captureUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downValid <= 1'b0;
      upValid   <= 1'b0;
    end else begin
      if (strobes.captureDown)   downValid <= 1'b1;
      else if (strobes.wipeDown) downValid <= 1'b0;
      if (strobes.captureUp)     upValid <= 1'b1;
      else if (strobes.wipeUp)   upValid <= 1'b0;
    end
  end

  // R2
  a_r2_enter_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    enterBackup |=> downValid);
  // R3
  a_r3_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (downValid && !clearStamps) |=> downValid);
  // R4
  a_r4_exit_sets_valid: assert property (@(posedge clk) disable iff (!rstN)
    exitBackup |=> upValid);
  // R6
  a_r6_clear_drops_down: assert property (@(posedge clk) disable iff (!rstN)
    (clearStamps && !enterBackup) |=> !downValid);
  a_r6_clear_drops_up: assert property (@(posedge clk) disable iff (!rstN)
    (clearStamps && !exitBackup) |=> !upValid);
  // R7
  a_r7_capture_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (clearStamps && enterBackup) |=> downValid);

endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import stamp_pkg::*;
#(
  parameter int FIELD_W     = FIELD_W_DEF,
  parameter int FIELD_COUNT = FIELD_COUNT_DEF,
  parameter int ADDR_W      = ADDR_W_DEF
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  stampStrobe_t                   strobes,
  input  logic [FIELD_W*FIELD_COUNT-1:0] timeNow,
  input  logic                           downValid,
  input  logic                           upValid,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [FIELD_W-1:0]             rdData
);
  localparam int TIME_W   = FIELD_W * FIELD_COUNT;
  localparam int IDX_W    = ADDR_W - 1;
  localparam int FLAG_IDX = (1 << IDX_W) - 1;
  localparam int BANKS    = 2;

  logic [TIME_W-1:0] bankReg [BANKS];
  logic [BANKS-1:0]  bankCapture;
  logic [BANKS-1:0]  bankWipe;

  assign bankCapture = {strobes.captureUp, strobes.captureDown};
  assign bankWipe    = {strobes.wipeUp, strobes.wipeDown};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               bankReg[b] <= '0;
      else if (bankCapture[b]) bankReg[b] <= timeNow;
      else if (bankWipe[b])    bankReg[b] <= '0;
    end
  end

  logic                 bankSel;
  logic [IDX_W-1:0]     fieldIdx;
  logic [FIELD_W-1:0]   flagByte;
  logic [FIELD_W-1:0]   selByte;

  assign bankSel  = rdAddr[ADDR_W-1];
  assign fieldIdx = rdAddr[IDX_W-1:0];
  assign flagByte = {{(FIELD_W-2){1'b0}}, upValid, downValid};

  always_comb begin
    selByte = '0;
    for (int f = 0; f < FIELD_COUNT; f++) begin
      if (int'(fieldIdx) == f) selByte = bankReg[bankSel][f*FIELD_W +: FIELD_W];
    end
    if (int'(fieldIdx) == FLAG_IDX) selByte = flagByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= selByte;
  end

  // R3
  a_r3_keep_first: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.captureDown && !strobes.wipeDown) |=> $stable(bankReg[0]));
  // R5
  a_r5_up_latest: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureUp |=> (bankReg[1] == $past(timeNow)));
  // R8
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

// File: rtl/stamp_top.sv
module stamp_top
  import stamp_pkg::*;
#(
  parameter int FIELD_W     = FIELD_W_DEF,
  parameter int FIELD_COUNT = FIELD_COUNT_DEF,
  parameter int ADDR_W      = ADDR_W_DEF
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           enterBackup,
  input  logic                           exitBackup,
  input  logic [FIELD_W*FIELD_COUNT-1:0] timeNow,
  input  logic                           clearStamps,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              rdAddr,
  output logic [FIELD_W-1:0]             rdData
);
  stampStrobe_t strobes;
  logic         downValid;
  logic         upValid;

  stamp_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enterBackup(enterBackup),
    .exitBackup (exitBackup),
    .clearStamps(clearStamps),
    .strobes    (strobes),
    .downValid  (downValid),
    .upValid    (upValid)
  );

  stamp_regs #(
    .FIELD_W    (FIELD_W),
    .FIELD_COUNT(FIELD_COUNT),
    .ADDR_W     (ADDR_W)
  ) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .timeNow  (timeNow),
    .downValid(downValid),
    .upValid  (upValid),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );
endmodule

// File: tb/stamp_top_test.sv
module stamp_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enterBackup = 1'b0;
  logic        exitBackup = 1'b0;
  logic [55:0] timeNow = '0;
  logic        clearStamps = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [7:0]  rdData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stamp_top uut (
    .clk(clk), .rstN(rstN), .enterBackup(enterBackup), .exitBackup(exitBackup),
    .timeNow(timeNow), .clearStamps(clearStamps), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData)
  );

  function automatic logic [55:0] mkTime(input logic [7:0] seed);
    logic [55:0] t;
    for (int i = 0; i < 7; i++) t[i*8 +: 8] = seed + 8'(i * 17);
    return t;
  endfunction

  task automatic readByte(input logic [3:0] addr, output logic [7:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = addr;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic checkByte(input logic [3:0] addr, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    readByte(addr, got);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d got=%h exp=%h", tag, addr, got, exp);
    end
  endtask

  task automatic checkBank(input bit bank, input logic [55:0] exp, input string tag);
    for (int i = 0; i < 7; i++) checkByte({bank, 3'(i)}, exp[i*8 +: 8], tag);
  endtask

  task automatic pulse(input bit en, input bit ex, input bit clr, input logic [55:0] t);
    @(negedge clk);
    enterBackup = en; exitBackup = ex; clearStamps = clr; timeNow = t;
    @(negedge clk);
    enterBackup = 1'b0; exitBackup = 1'b0; clearStamps = 1'b0;
    timeNow = ~t;
  endtask

  task automatic t_reset();
    checkByte(4'd7, 8'h00, "R1 flags");
    checkBank(1'b0, '0, "R1 down bank");
    checkBank(1'b1, '0, "R1 up bank");
  endtask

  task automatic t_down_first();
    pulse(1, 0, 0, mkTime(8'h10));
    checkBank(1'b0, mkTime(8'h10), "R2 down capture");
    checkByte(4'd7, 8'h01, "R2 R8 flag byte");
    pulse(1, 0, 0, mkTime(8'h20));
    checkBank(1'b0, mkTime(8'h10), "R3 earliest kept");
  endtask

  task automatic t_up_latest();
    pulse(0, 1, 0, mkTime(8'h30));
    checkBank(1'b1, mkTime(8'h30), "R4 up capture");
    checkByte(4'd15, 8'h03, "R4 R8 flag byte bank1");
    pulse(0, 1, 0, mkTime(8'h40));
    checkBank(1'b1, mkTime(8'h40), "R5 latest kept");
  endtask

  task automatic t_clear();
    pulse(0, 0, 1, mkTime(8'h55));
    checkByte(4'd7, 8'h00, "R6 flags");
    checkBank(1'b0, '0, "R6 down zero");
    checkBank(1'b1, '0, "R6 up zero");
  endtask

  task automatic t_collide();
    pulse(1, 1, 0, mkTime(8'h60));
    pulse(1, 0, 1, mkTime(8'h70));
    checkBank(1'b0, mkTime(8'h70), "R7 capture wins");
    checkBank(1'b1, '0, "R7 other bank wiped");
    checkByte(4'd7, 8'h01, "R7 flags");
  endtask

  task automatic t_both();
    pulse(0, 0, 1, '0);
    pulse(1, 1, 0, mkTime(8'h90));
    checkBank(1'b0, mkTime(8'h90), "R9 down");
    checkBank(1'b1, mkTime(8'h90), "R9 up");
    checkByte(4'd7, 8'h03, "R9 flags");
  endtask

  task automatic t_read_hold();
    logic [7:0] first;
    readByte(4'd2, first);
    @(negedge clk);
    rdAddr = 4'd7;
    @(negedge clk);
    total++;
    if (rdData !== first) begin
      bad++;
      $display("FAIL R8 hold got=%h exp=%h", rdData, first);
    end
    total++;
    if (first !== mkTime(8'h90)[23:16]) begin
      bad++;
      $display("FAIL R8 field order got=%h exp=%h", first, mkTime(8'h90)[23:16]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_down_first();
    t_up_latest();
    t_clear();
    t_collide();
    t_both();
    t_read_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule